// File: doc/BRIEF.md
# Split-Transaction Read Request Throttle

This block sits in front of a bus master's read-request issue point. Two requesters share that issue point: a transmit side and a receive side. Each new read request occupies one split-transaction slot until its completion is retired. The block keeps a running count of open slots and decides, cycle by cycle, which requester may issue. A 3-bit code sets the overall ceiling on open slots. A 5-bit limit sets a lower ceiling for the transmit side only, so receive traffic always keeps some headroom.

Each requester raises its request line and holds it until it sees its grant. A grant is combinational in the same cycle as the request and means the request was issued on that clock edge. A requester that is not granted is back-pressured and must keep its request asserted. At most one request is issued per cycle. The completion side pulses a retire input once per finished transaction.

Top module: `split_read_throttle`

## Requirements
- R1: The ceiling code selects the overall limit on open transactions: code 0 gives 1, 1 gives 2, 2 gives 3, 3 gives 4, 4 gives 8, 5 gives 12, 6 gives 16 and 7 gives 32.
- R2: A receive request is granted only while the open count is below the ceiling, and is granted in that case unless a rule below gives the cycle to transmit.
- R3: With a non-zero transmit limit, a transmit request is granted only while the open count is below both that limit and the ceiling.
- R4: A transmit limit of 0 places no extra bound on transmit, which is then bounded by the ceiling alone.
- R5: No more than one grant is asserted in any cycle, and a grant appears in the same cycle as the request it answers.
- R6: When both requesters are eligible and exactly one slot below the ceiling is free, the receive side is granted.
- R7: In every other cycle where both are eligible, the side that did not receive the most recent grant is granted.
- R8: The open count rises by one on each grant and falls by one on each retire pulse; a grant and a retire in the same cycle leave it unchanged.
- R9: A retire pulse while the open count is 0 does not lower the count, and the error output is high for exactly the following cycle.
- R10: After reset the open count is 0, the error output is low, and the most recent grant is taken to be transmit, so the first contended cycle goes to receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_req | input | 1 | Transmit requester wants to issue a read |
| tx_gnt | output | 1 | Transmit request issued this cycle |
| rx_req | input | 1 | Receive requester wants to issue a read |
| rx_gnt | output | 1 | Receive request issued this cycle |
| cpl_retire | input | 1 | One open transaction has completed |
| ceil_code | input | 3 | Overall ceiling code (see R1) |
| tx_share_lim | input | 5 | Transmit-only limit, 0 meaning none |
| open_count | output | 6 | Number of open transactions |
| underflow_err | output | 1 | Retire arrived with nothing open |

## Verification
On every cycle the assertions check that grants are mutually exclusive, that no grant is given at or above the applicable ceiling, that the receive side takes the last free slot, that transmit cannot win two contended rounds back to back, and that a retire at zero leaves the count at zero and raises the error flag. The assertions cannot show that each ceiling code produces the right number. Nor can they show that a full fill stops exactly at the level set by the ceiling and the transmit limit, or that a zero transmit limit really lifts the transmit bound. Those results come from the bench's sweep over every code and a spread of transmit limits, with fill, mixed and drain phases.

// File: rtl/srt_pkg.sv
`timescale 1ns/1ps
package srt_pkg;
  localparam int CODE_W   = 3;
  localparam int SHARE_W  = 5;
  localparam int CEIL_TOP = 32;
  localparam int CNT_W    = $clog2(CEIL_TOP + 1);

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic {WIN_RX = 1'b0, WIN_TX = 1'b1} winner_e;

  // Non-linear ceiling: 1..4 for low codes, steps of 4 above, top code jumps.
  function automatic cnt_t ceil_of(input logic [CODE_W-1:0] c);
    cnt_t r;
    if (c == CODE_W'(7))
      r = cnt_t'(CEIL_TOP);
    else if (c[CODE_W-1])
      r = cnt_t'({c, 2'b00}) - cnt_t'(8);
    else
      r = cnt_t'(c) + cnt_t'(1);
    return r;
  endfunction
endpackage

// File: rtl/srt_headroom.sv
`timescale 1ns/1ps
module srt_headroom
  import srt_pkg::*;
#(
  parameter int SHARE_W = srt_pkg::SHARE_W
) (
  input  cnt_t                count,
  input  logic [CODE_W-1:0]   ceil_code,
  input  logic [SHARE_W-1:0]  share_lim,
  output cnt_t                ceiling,
  output logic                rx_room,
  output logic                tx_room,
  output logic                last_slot
);
  cnt_t share_ext;
  logic share_off;

  always_comb begin
    ceiling   = ceil_of(ceil_code);
    share_ext = cnt_t'(share_lim);
    share_off = (share_lim == '0);
    rx_room   = (count < ceiling);
    tx_room   = rx_room && (share_off || (count < share_ext));
    last_slot = ((count + cnt_t'(1)) == ceiling);
  end
endmodule

// File: rtl/srt_arbiter.sv
`timescale 1ns/1ps
module srt_arbiter
  import srt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tx_req,
  input  logic rx_req,
  input  logic tx_room,
  input  logic rx_room,
  input  logic last_slot,
  output logic tx_gnt,
  output logic rx_gnt
);
  winner_e last_q;
  logic    tx_elig, rx_elig, contend;

  always_comb begin
    tx_elig = tx_req && tx_room;
    rx_elig = rx_req && rx_room;
    contend = tx_elig && rx_elig;
    if (contend) begin
      if (last_slot || (last_q == WIN_TX)) begin
        rx_gnt = 1'b1;
        tx_gnt = 1'b0;
      end else begin
        rx_gnt = 1'b0;
        tx_gnt = 1'b1;
      end
    end else begin
      rx_gnt = rx_elig;
      tx_gnt = tx_elig;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      last_q <= WIN_TX;
    else if (tx_gnt)
      last_q <= WIN_TX;
    else if (rx_gnt)
      last_q <= WIN_RX;
  end

  // R5: never two grants at once
  p_one_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_gnt, rx_gnt}));

  // R6: last free slot goes to receive
  p_last_slot_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (contend && last_slot) |-> rx_gnt);

  // R7: transmit cannot win two contended rounds in a row
  p_alternate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_gnt |=> (!(tx_req && rx_req && tx_room && rx_room) || rx_gnt));
endmodule

// File: rtl/srt_counter.sv
`timescale 1ns/1ps
module srt_counter
  import srt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic retire,
  output cnt_t count,
  output logic underflow
);
  localparam cnt_t ONE = cnt_t'(1);

  logic at_zero, dec;

  always_comb begin
    at_zero = (count == '0);
    dec     = retire && !at_zero;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count     <= '0;
      underflow <= 1'b0;
    end else begin
      underflow <= retire && at_zero;
      case ({inc, dec})
        2'b10:   count <= count + ONE;
        2'b01:   count <= count - ONE;
        default: count <= count;
      endcase
    end
  end

  // R9: retire at zero cannot wrap the count
  p_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && (count == '0) && !inc) |=> (count == '0));

  // R9: retire at zero raises the error the next cycle
  p_err_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && (count == '0)) |=> underflow);

  // R8: simultaneous grant and retire hold the count
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && retire && (count != '0)) |=> $stable(count));
endmodule

// File: rtl/split_read_throttle.sv
`timescale 1ns/1ps
module split_read_throttle
  import srt_pkg::*;
#(
  parameter int SHARE_W = srt_pkg::SHARE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_req,
  output logic               tx_gnt,
  input  logic               rx_req,
  output logic               rx_gnt,
  input  logic               cpl_retire,
  input  logic [CODE_W-1:0]  ceil_code,
  input  logic [SHARE_W-1:0] tx_share_lim,
  output logic [CNT_W-1:0]   open_count,
  output logic               underflow_err
);
  cnt_t ceiling;
  logic rx_room, tx_room, last_slot;

  srt_headroom #(.SHARE_W(SHARE_W)) u_room (
    .count     (open_count),
    .ceil_code (ceil_code),
    .share_lim (tx_share_lim),
    .ceiling   (ceiling),
    .rx_room   (rx_room),
    .tx_room   (tx_room),
    .last_slot (last_slot)
  );

  srt_arbiter u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_req    (tx_req),
    .rx_req    (rx_req),
    .tx_room   (tx_room),
    .rx_room   (rx_room),
    .last_slot (last_slot),
    .tx_gnt    (tx_gnt),
    .rx_gnt    (rx_gnt)
  );

  srt_counter u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc       (tx_gnt || rx_gnt),
    .retire    (cpl_retire),
    .count     (open_count),
    .underflow (underflow_err)
  );

  // R2: receive grant only below the ceiling
  p_rx_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_gnt |-> (open_count < ceiling));

  // R3: transmit grant only below a non-zero transmit limit
  p_tx_share_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_gnt && (tx_share_lim != '0)) |-> (open_count < CNT_W'(tx_share_lim)));

  // R8: count never exceeds the largest ceiling
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (open_count <= CNT_W'(CEIL_TOP)));
endmodule

// File: tb/split_read_throttle_test.sv
`timescale 1ns/1ps
module split_read_throttle_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_req = 1'b0, rx_req = 1'b0, cpl_retire = 1'b0;
  logic [2:0] ceil_code = 3'd0;
  logic [4:0] tx_share_lim = 5'd0;
  logic       tx_gnt, rx_gnt, underflow_err;
  logic [5:0] open_count;

  int vectors = 0;
  int fails   = 0;

  // model state
  int m_cnt, m_ceil, m_sh;
  bit m_last_tx, m_err;
  logic [15:0] lf = 16'hACE1;

  always #4 clk = ~clk;

  split_read_throttle uut (
    .clk(clk), .rst_n(rst_n),
    .tx_req(tx_req), .tx_gnt(tx_gnt),
    .rx_req(rx_req), .rx_gnt(rx_gnt),
    .cpl_retire(cpl_retire),
    .ceil_code(ceil_code), .tx_share_lim(tx_share_lim),
    .open_count(open_count), .underflow_err(underflow_err)
  );

  function automatic int ceil_ref(input int c);
    case (c)
      0: return 1;  1: return 2;  2: return 3;  3: return 4;
      4: return 8;  5: return 12; 6: return 16; default: return 32;
    endcase
  endfunction

  task automatic check(input int act, input int exp, input string tag, input string what);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (code %0d limit %0d)",
               tag, what, act, exp, ceil_code, tx_share_lim);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tx_req = 0; rx_req = 0; cpl_retire = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_cnt = 0; m_last_tx = 1'b1; m_err = 1'b0;
    #1;
    check(int'(open_count), 0, "R10", "count after reset");
    check(int'(underflow_err), 0, "R10", "error after reset");
  endtask

  task automatic step(input bit t, input bit r, input bit p);
    bit troom, rroom, last, contend, e_tx, e_rx;
    string rtag, ttag;
    @(negedge clk);
    tx_req = t; rx_req = r; cpl_retire = p;
    #1;
    rroom   = (m_cnt < m_ceil);
    troom   = rroom && ((m_sh == 0) || (m_cnt < m_sh));
    last    = (m_cnt + 1 == m_ceil);
    contend = t && r && troom && rroom;
    if (contend) begin
      e_rx = last || m_last_tx;
      e_tx = !e_rx;
    end else begin
      e_rx = r && rroom;
      e_tx = t && troom;
    end
    rtag = contend ? (last ? "R6" : "R7") : "R2";
    ttag = contend ? "R7" : ((m_sh == 0) ? "R4" : "R3");
    check(int'(open_count), m_cnt, "R8", "open count");
    check(int'(underflow_err), int'(m_err), "R9", "underflow flag");
    check(int'(rx_gnt), int'(e_rx), rtag, "rx grant");
    check(int'(tx_gnt), int'(e_tx), ttag, "tx grant");
    check(int'(tx_gnt && rx_gnt), 0, "R5", "double grant");
    @(posedge clk);
    if (e_tx) m_last_tx = 1'b1;
    else if (e_rx) m_last_tx = 1'b0;
    m_err = p && (m_cnt == 0);
    m_cnt = m_cnt + int'(e_tx || e_rx) - int'(p && (m_cnt != 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int shs[8] = '{0, 1, 2, 3, 5, 7, 12, 31};
    for (int c = 0; c < 8; c++) begin
      for (int s = 0; s < 8; s++) begin
        ceil_code = 3'(c); tx_share_lim = 5'(shs[s]);
        m_ceil = ceil_ref(c); m_sh = shs[s];
        do_reset();
        // transmit-only fill
        for (int i = 0; i < 34; i++) step(1, 0, 0);
        @(negedge clk); #1;
        if (m_sh == 0)
          check(int'(open_count), m_ceil, "R4", "tx fill level, no limit");
        else
          check(int'(open_count), (m_sh < m_ceil) ? m_sh : m_ceil, "R3", "tx fill level");
        // receive tops up to the ceiling
        for (int i = 0; i < 34; i++) step(0, 1, 0);
        @(negedge clk); #1;
        check(int'(open_count), ceil_ref(c), "R1", "ceiling for code");
        // drain half then mixed traffic
        for (int i = 0; i < m_ceil / 2 + 1; i++) step(0, 0, 1);
        for (int i = 0; i < 60; i++) begin
          lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
          step(lf[0], lf[3], lf[5]);
        end
        // both requesting continuously: contention, last slot
        for (int i = 0; i < 20; i++) step(1, 1, (i % 3) == 0);
        // full drain and retirements at zero
        for (int i = 0; i < 36; i++) step(0, 0, 1);
        step(1, 0, 1);
        step(0, 0, 1);
        step(0, 0, 1);
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule